// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the digital frequency-offset code that a fractional synthesizer loop follows to spread its output clock and lower peak emissions. The code traces a triangle that runs on the reference clock. One full rise-and-fall takes 512 reference cycles. The offset is given in hundredths of a percent. It swings between a lower and an upper bound chosen by a 3-bit magnitude select and a 1-bit spread-type strap.

The strap is sampled once, on the first clock edge after reset is released. From then on it is ignored, because the pad it arrives on is reused for another purpose. The magnitude select passes through a two-flop synchronizer. A new value waits for the next profile start, so a triangle that has begun always runs to its end. A one-cycle strobe marks the start of each profile, where the offset sits at the lower bound. A valid flag tells the loop when the code is meaningful.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is low, offset_o is 0 and both start_o and valid_o are 0.
- R2: spread_type_i is captured on the first rising clock edge with reset high. Later changes of it have no effect until the next reset.
- R3: valid_o goes to 1 on the second rising edge after reset release and then stays at 1. While valid_o is 0, offset_o is 0.
- R4: start_o is a one-cycle pulse. It is high in the first valid cycle and then once every 512 cycles.
- R5: Let p be the number of cycles since the last start pulse (0..511), r = p for p < 256 and r = 512 - p otherwise, and lo/hi the bounds. Then offset_o = lo + floor((hi - lo) * r / 256). So the offset equals lo at the start pulse and hi at p = 256.
- R6: With the captured type at 1 and a magnitude code s of 0 to 6, the bounds are ±25*(s+1), which is ±0.25% up to ±1.75%.
- R7: With the captured type at 0, code 0 gives bounds -50..0 and code 1 gives -100..0. Codes 2 to 6 give the type-1 bounds shifted by -50, so code 6 gives -225..+125.
- R8: Magnitude code 7 turns modulation off: offset_o stays 0 while start_o keeps pulsing every 512 cycles.
- R9: mag_sel_i is an unsigned 3-bit code that goes through two synchronizing flops. The profile takes the synchronized value only on the edge that begins a profile. A change in the middle of a profile leaves the current triangle unchanged.
- R10: offset_o is a 10-bit two's-complement value in units of 0.01% and always lies within -225..+175.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_type_i | input | 1 | Spread-type strap: 1 centered, 0 shifted down |
| mag_sel_i | input | 3 | Magnitude select code; 7 turns modulation off |
| offset_o | output | 10 | Signed frequency offset, 0.01% units |
| start_o | output | 1 | One-cycle strobe at the start of each profile |
| valid_o | output | 1 | Offset code is meaningful |

## Verification
The assertions assume that the strap keeps one level across the release of reset. They also assume that the magnitude select is stable for at least two clock cycles around each profile boundary that is meant to pick up a new value. The stimulus holds both inputs constant across every reset release. It changes the select only at falling edges, either in the middle of a profile or well ahead of a boundary. It toggles the strap only after the capture, so both the ignore rule and the deferred select update can be seen at the ports.

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int PH_W  = 9,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spread_type_i,
  input  logic [2:0]       mag_sel_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             start_o,
  output logic             valid_o
);
  localparam int HALF_SH = PH_W - 1;
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic            cap_q, type_q, valid_q;
  logic [2:0]      sc_s1, sc_s2, act_sc;
  logic [PH_W-1:0] ph;
  logic            load;

  assign load = (cap_q && !valid_q) || (valid_q && ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      type_q  <= 1'b1;
      valid_q <= 1'b0;
      sc_s1   <= 3'd7;
      sc_s2   <= 3'd7;
      act_sc  <= 3'd7;
      ph      <= '0;
    end else begin
      sc_s1 <= mag_sel_i;
      sc_s2 <= sc_s1;
      if (!cap_q) type_q <= spread_type_i;
      cap_q <= 1'b1;
      if (cap_q) valid_q <= 1'b1;
      if (load) act_sc <= sc_s2;
      if (valid_q) ph <= ph + 1'b1;
    end
  end

  logic signed [23:0] unit25, lo, hi, span, prod, off_full;
  logic [PH_W-1:0]    ramp;

  assign unit25 = 24'sd25 * ($signed({21'd0, act_sc}) + 24'sd1);

  always_comb begin
    if (act_sc == 3'd7) begin
      lo = '0;
      hi = '0;
    end else if (type_q) begin
      lo = -unit25;
      hi = unit25;
    end else if (act_sc == 3'd0) begin
      lo = -24'sd50;
      hi = '0;
    end else begin
      lo = -unit25 - 24'sd50;
      hi = unit25 - 24'sd50;
    end
  end

  assign ramp     = ph[PH_W-1] ? ('0 - ph) : ph;
  assign span     = hi - lo;
  assign prod     = span * $signed({{(24-PH_W){1'b0}}, ramp});
  assign off_full = lo + (prod >>> HALF_SH);

  assign offset_o = valid_q ? OFF_W'(off_full) : '0;
  assign start_o  = valid_q && (ph == '0);
  assign valid_o  = valid_q;
endmodule

// File: rtl/ssc_profile_gen_chk.sv
module ssc_profile_gen_chk (
  input logic              clk,
  input logic              rst_n,
  input logic signed [9:0] offset,
  input logic              start,
  input logic              valid,
  input logic              type_q,
  input logic [2:0]        act_sc
);
  p_type_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(type_q));

  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  p_zero_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> offset == 10'sd0);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  p_rise_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> offset >= $past(offset));

  p_off_is_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && act_sc == 3'd7) |-> offset == 10'sd0);

  p_select_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$stable(act_sc)) |-> start);

  p_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    offset >= -10'sd225 && offset <= 10'sd175);
endmodule

bind ssc_profile_gen ssc_profile_gen_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .offset (offset_o),
  .start  (start_o),
  .valid  (valid_o),
  .type_q (type_q),
  .act_sc (act_sc)
);

// File: tb/ssc_profile_gen_test.sv
module ssc_profile_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b1;
  logic [2:0] sel = 3'd7;
  logic [9:0] offset;
  logic       start, valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ssc_profile_gen uut (
    .clk(clk), .rst_n(rst_n), .spread_type_i(strap), .mag_sel_i(sel),
    .offset_o(offset), .start_o(start), .valid_o(valid)
  );

  // behavioural reference
  int m_cap, m_valid, m_type, m_ph, m_act;
  int sq[$] = '{7, 7};

  function automatic int lo_of(int t, int s);
    if (s == 7) return 0;
    if (t == 1) return -25 * (s + 1);
    if (s == 0) return -50;
    return -25 * (s + 1) - 50;
  endfunction

  function automatic int hi_of(int t, int s);
    if (s == 7) return 0;
    if (t == 1) return 25 * (s + 1);
    if (s <= 1) return 0;
    return 25 * (s + 1) - 50;
  endfunction

  function automatic int exp_off(int t, int s, int p);
    int r = (p < 256) ? p : 512 - p;
    int lo = lo_of(t, s);
    return lo + ((hi_of(t, s) - lo) * r) / 256;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cap = 0; m_valid = 0; m_ph = 0; m_act = 7; sq = '{7, 7};
    end else begin
      int nxt_act = m_act;
      if ((m_cap && !m_valid) || (m_valid && m_ph == 511)) nxt_act = sq[1];
      if (m_valid) m_ph = (m_ph + 1) % 512;
      if (m_cap) m_valid = 1;
      if (!m_cap) m_type = int'(strap);
      m_cap = 1;
      m_act = nxt_act;
      sq = '{int'(sel), sq[0]};
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of();
    if (!m_valid) return "R3";
    if (m_act == 7) return "R8";
    return m_type ? "R6" : "R7";
  endfunction

  int last_start = -1, cyc = 0;
  always @(negedge clk) begin
    if (!done) begin
      int eo = m_valid ? exp_off(m_type, m_act, m_ph) : 0;
      int eo_s = $signed(offset);
      cyc++;
      chk(eo_s == eo, {tag_of(), " R5 R10 offset"}, eo_s, eo);
      chk(valid == (m_valid != 0), "R3 valid", int'(valid), m_valid);
      chk(start == (m_valid && m_ph == 0), "R4 start", int'(start), int'(m_valid && m_ph == 0));
      if (start && rst_n) begin
        if (last_start >= 0) chk(cyc - last_start == 512, "R4 period", cyc - last_start, 512);
        last_start = cyc;
      end
      if (!rst_n) last_start = -1;
    end
  end

  task automatic wait_start();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (start) return;
    end
    chk(0, "R4 no start", 0, 1);
  endtask

  task automatic skip(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(bit t, logic [2:0] s);
    @(negedge clk);
    rst_n = 0; strap = t; sel = s;
    skip(3);
    chk(offset == 0 && !start && !valid, "R1 reset state", int'(valid), 0);
    rst_n = 1;
  endtask

  task automatic profile_ends(int t, int s);
    wait_start();
    chk($signed(offset) == lo_of(t, s), "R5 low at start", $signed(offset), lo_of(t, s));
    skip(256);
    chk($signed(offset) == hi_of(t, s), t ? "R6 peak" : "R7 peak", $signed(offset), hi_of(t, s));
  endtask

  initial begin
    do_reset(1, 3'd7);
    skip(1);
    chk(valid == 0, "R3 not yet valid", int'(valid), 0);
    skip(1);
    chk(valid == 1, "R3 valid after capture", int'(valid), 1);
    skip(100);
    chk($signed(offset) == 0, "R8 off code", $signed(offset), 0);
    sel = 3'd3;
    skip(50);
    chk($signed(offset) == 0, "R9 deferred select", $signed(offset), 0);
    profile_ends(1, 3);
    strap = 0;
    profile_ends(1, 3);
    chk($signed(offset) == 100, "R2 strap ignored", $signed(offset), 100);
    for (int s = 0; s < 7; s++) begin
      sel = 3'(s);
      skip(300);
      profile_ends(1, s);
    end
    do_reset(0, 3'd0);
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      skip(300);
      profile_ends(0, s);
    end
    sel = 3'd6;
    skip(300);
    strap = 1;
    profile_ends(0, 6);
    chk($signed(offset) == 125, "R2 strap ignored type0", $signed(offset), 125);
    skip(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule